// File: doc/BRIEF.md
# Power-Tracking Sample Bit Selector

This block narrows a stream of complex samples from a 12-bit converter down to 4 bits per component. Each component is shifted right arithmetically by a run-time amount and the result is clamped into the signed 4-bit range, so the 4-bit window can slide anywhere across the wide input. Alongside the data path, the block measures the mean of I*I + Q*Q over fixed blocks of samples. An outside supervisor reads that figure and writes back a new shift, closing a gain loop.

A tiny word-addressed register space carries both values. Word 0 holds the shift amount and can be read and written. Word 1 returns the latest power average and cannot be written. A receiver with several frequency bands places one copy of this block per band, and each copy has its own register space.

Top module: `bit_window_selector`

## Requirements
- R1: After reset, word 0 reads 8, word 1 reads 0 and `out_valid` is low.
- R2: Each output component equals the signed input component shifted right arithmetically (rounding toward minus infinity) by the current shift amount, in two's complement.
- R3: A shifted value above +7 is output as +7, and one below -8 is output as -8, instead of wrapping.
- R4: `out_valid` is high exactly two clock cycles after each cycle in which `in_valid` is high, and never otherwise.
- R5: A write to word 0 (`reg_addr` = 0) sets the shift amount from `reg_wr_data`, read as an unsigned 32-bit number. Any value above 8 is stored as 8. Reading word 0 returns the stored amount, zero-extended.
- R6: A sample accepted in the same cycle as a shift write is sliced with the old shift, and every later sample uses the new one. No sample ever mixes two settings.
- R7: Word 1 (`reg_addr` = 1) returns the sum of I*I + Q*Q over the last complete block of 2^AVG_LOG2 accepted samples, shifted right by AVG_LOG2 and zero-extended. It changes in the cycle after a block's last sample is accepted and holds its value until the next block completes.
- R8: Writes to word 1 do not change the power value. Reads of any word other than 0 and 1 return zero.
- R9: Cycles with `in_valid` low do not count toward a power block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 12 | In-phase input, signed |
| in_q | input | 12 | Quadrature input, signed |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 4 | In-phase output, signed |
| out_q | output | 4 | Quadrature output, signed |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Read data for the word at `reg_addr`, combinational |

## Verification
The properties assume that `in_valid`, `reg_wr_en` and `reg_addr` are known, 0 or 1, in every cycle once reset has been released. They also assume that reset lasts at least one clock edge and that `in_valid` is low while reset is asserted. The bench keeps to these assumptions: it drives every input to a defined value before reset is released and changes inputs only on falling edges. It also holds `in_valid` low during each reset it applies, including the reset before the power test, which starts that test with an empty block.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int IN_W      = 12;
    localparam int OUT_W     = 4;
    localparam int SHIFT_MAX = IN_W - OUT_W;
    localparam int SHIFT_W   = $clog2(SHIFT_MAX + 1);
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int MAG_W     = 2 * IN_W;
    localparam int OUT_HI    = (1 << (OUT_W - 1)) - 1;
    localparam int OUT_LO    = -(1 << (OUT_W - 1));

    typedef struct packed {
        logic signed [IN_W-1:0] re;
        logic signed [IN_W-1:0] im;
    } wide_iq_t;

    typedef struct packed {
        logic signed [OUT_W-1:0] re;
        logic signed [OUT_W-1:0] im;
    } narrow_iq_t;

    typedef enum logic [ADDR_W-1:0] {
        WORD_SHIFT = ADDR_W'(0),
        WORD_POWER = ADDR_W'(1)
    } reg_word_e;

    // Arithmetic shift followed by clamping into the narrow signed range.
    function automatic logic signed [OUT_W-1:0] window_sat(
        input logic signed [IN_W-1:0] x,
        input logic [SHIFT_W-1:0]     sh
    );
        logic signed [IN_W-1:0] t;
        t = x >>> sh;
        if (t > IN_W'(OUT_HI))
            return OUT_W'(OUT_HI);
        else if (t < IN_W'(OUT_LO))
            return OUT_W'(OUT_LO);
        else
            return t[OUT_W-1:0];
    endfunction

    // I*I + Q*Q; the largest value is exactly 2**(MAG_W-1).
    function automatic logic [MAG_W-1:0] sq_mag(input wide_iq_t s);
        logic signed [MAG_W-1:0] er;
        logic signed [MAG_W-1:0] ei;
        logic signed [MAG_W-1:0] pr;
        logic signed [MAG_W-1:0] pi;
        er = {{IN_W{s.re[IN_W-1]}}, s.re};
        ei = {{IN_W{s.im[IN_W-1]}}, s.im};
        pr = er * er;
        pi = ei * ei;
        return $unsigned(pr) + $unsigned(pi);
    endfunction

endpackage

// File: rtl/sbs_cfg_regs.sv
module sbs_cfg_regs
    import sbs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [MAG_W-1:0]     power_in,
    output logic [SHIFT_W-1:0]   shift_cfg,
    output logic [DATA_W-1:0]    rd_data
);

    logic [SHIFT_W-1:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= SHIFT_W'(SHIFT_MAX);
        end else if (wr_en && addr == WORD_SHIFT) begin
            if (wr_data > DATA_W'(SHIFT_MAX))
                shift_q <= SHIFT_W'(SHIFT_MAX);
            else
                shift_q <= wr_data[SHIFT_W-1:0];
        end
    end

    assign shift_cfg = shift_q;

    // The power word has no write path: writes addressed to it fall through.
    always_comb begin
        case (addr)
            WORD_SHIFT: rd_data = DATA_W'(shift_q);
            WORD_POWER: rd_data = DATA_W'(power_in);
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/sbs_window.sv
module sbs_window
    import sbs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  wide_iq_t            in_s,
    input  logic [SHIFT_W-1:0]  shift_cfg,
    output logic                out_valid,
    output narrow_iq_t          out_s
);

    // Stage 1: the sample and the shift it will use are captured together.
    logic               v1_q;
    wide_iq_t           s1_q;
    logic [SHIFT_W-1:0] sh1_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1_q  <= 1'b0;
            s1_q  <= '0;
            sh1_q <= SHIFT_W'(SHIFT_MAX);
        end else begin
            v1_q <= in_valid;
            if (in_valid) begin
                s1_q  <= in_s;
                sh1_q <= shift_cfg;
            end
        end
    end

    // Stage 2: slice and clamp.
    logic       v2_q;
    narrow_iq_t s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v2_q <= 1'b0;
            s2_q <= '0;
        end else begin
            v2_q <= v1_q;
            if (v1_q) begin
                s2_q.re <= window_sat(s1_q.re, sh1_q);
                s2_q.im <= window_sat(s1_q.im, sh1_q);
            end
        end
    end

    assign out_valid = v2_q;
    assign out_s     = s2_q;

endmodule

// File: rtl/sbs_power_est.sv
module sbs_power_est
    import sbs_pkg::*;
#(
    parameter int AVG_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  wide_iq_t          in_s,
    output logic [MAG_W-1:0]  power,
    output logic              blk_done
);

    localparam int ACC_W = MAG_W + AVG_LOG2;
    localparam int CNT_W = (AVG_LOG2 < 1) ? 1 : AVG_LOG2;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'((1 << AVG_LOG2) - 1);

    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic [MAG_W-1:0] power_q;
    logic [MAG_W-1:0] mag;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] avg_full;

    assign mag      = sq_mag(in_s);
    assign sum      = acc_q + ACC_W'(mag);
    assign avg_full = sum >> AVG_LOG2;
    assign blk_done = in_valid && (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            cnt_q   <= '0;
            power_q <= '0;
        end else if (in_valid) begin
            if (blk_done) begin
                acc_q   <= '0;
                cnt_q   <= '0;
                power_q <= avg_full[MAG_W-1:0];
            end else begin
                acc_q <= sum;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign power = power_q;

endmodule

// File: rtl/bit_window_selector.sv
module bit_window_selector
    import sbs_pkg::*;
#(
    parameter int AVG_LOG2 = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [IN_W-1:0]       in_i,
    input  logic [IN_W-1:0]       in_q,
    output logic                  out_valid,
    output logic [OUT_W-1:0]      out_i,
    output logic [OUT_W-1:0]      out_q,
    input  logic                  reg_wr_en,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wr_data,
    output logic [DATA_W-1:0]     reg_rd_data
);

    wide_iq_t           in_s;
    narrow_iq_t         out_s;
    logic [SHIFT_W-1:0] shift_cfg;
    logic [MAG_W-1:0]   power_w;
    logic               blk_done;

    assign in_s.re = in_i;
    assign in_s.im = in_q;

    sbs_cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wr_data  (reg_wr_data),
        .power_in (power_w),
        .shift_cfg(shift_cfg),
        .rd_data  (reg_rd_data)
    );

    sbs_window u_window (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_s     (in_s),
        .shift_cfg(shift_cfg),
        .out_valid(out_valid),
        .out_s    (out_s)
    );

    sbs_power_est #(.AVG_LOG2(AVG_LOG2)) u_power (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .in_s    (in_s),
        .power   (power_w),
        .blk_done(blk_done)
    );

    assign out_i = out_s.re;
    assign out_q = out_s.im;

endmodule

// File: rtl/bit_window_selector_chk.sv
module bit_window_selector_chk
    import sbs_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                out_valid,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic [SHIFT_W-1:0]  shift_cfg,
    input logic [MAG_W-1:0]    power,
    input logic                blk_done
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $fell(rst) |-> (shift_cfg == SHIFT_W'(SHIFT_MAX) && !out_valid && power == '0));

    // R4
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid);

    // R4
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##1 !out_valid);

    // R5
    shift_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == WORD_SHIFT && wr_data > DATA_W'(SHIFT_MAX))
        |=> shift_cfg == SHIFT_W'(SHIFT_MAX));

    // R5
    shift_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == WORD_SHIFT && wr_data <= DATA_W'(SHIFT_MAX))
        |=> shift_cfg == $past(wr_data[SHIFT_W-1:0]));

    // R7 R8
    power_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !blk_done |=> $stable(power));

endmodule

bind bit_window_selector bit_window_selector_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .wr_en    (reg_wr_en),
    .addr     (reg_addr),
    .wr_data  (reg_wr_data),
    .shift_cfg(shift_cfg),
    .power    (power_w),
    .blk_done (blk_done)
);

// File: tb/bit_window_selector_tb_top.sv
`timescale 1ns/1ps
module bit_window_selector_tb_top;

    localparam int AVG_LOG2 = 4;
    localparam int BLK      = 1 << AVG_LOG2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [11:0] in_i = '0;
    logic [11:0] in_q = '0;
    logic        out_valid;
    logic [3:0]  out_i;
    logic [3:0]  out_q;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    bit_window_selector #(.AVG_LOG2(AVG_LOG2)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_slice(input int x, input int sh);
        int v;
        v = x >>> sh;
        if (v > 7) v = 7;
        if (v < -8) v = -8;
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; reg_wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic reg_write(input int a, input longint d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 4'(a); reg_wr_data = 32'(d);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input int a, output longint v);
        reg_addr = 4'(a);
        #0.5;
        v = longint'(reg_rd_data);
    endtask

    // Drive one sample, confirm the two-cycle latency and the sliced value.
    task automatic send_chk(input int i, input int q, input int sh, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_i = 12'(i); in_q = 12'(q);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R4 early", longint'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R4 late", longint'(out_valid), 1);
        check($signed(out_i) == ref_slice(i, sh), req, $signed(out_i), ref_slice(i, sh));
        check($signed(out_q) == ref_slice(q, sh), req, $signed(out_q), ref_slice(q, sh));
    endtask

    task automatic t_reset();
        longint v;
        do_reset();
        reg_read(0, v);
        check(v == 8, "R1 shift", v, 8);
        reg_read(1, v);
        check(v == 0, "R1 power", v, 0);
        check(out_valid == 1'b0, "R1 valid", longint'(out_valid), 0);
    endtask

    task automatic t_msb_window();
        send_chk(2047, -2048, 8, "R2 msb");
        send_chk(-1, 300, 8, "R2 msb");
    endtask

    task automatic t_low_window();
        reg_write(0, 0);
        send_chk(5, -3, 0, "R2 shift0");
        send_chk(100, -100, 0, "R3 sat");
        send_chk(8, -9, 0, "R3 edge");
    endtask

    task automatic t_mid_window();
        reg_write(0, 4);
        send_chk(-37, 100, 4, "R2 shift4");
        send_chk(2047, -2048, 4, "R3 sat4");
    endtask

    task automatic t_clamp();
        longint v;
        reg_write(0, 12);
        reg_read(0, v);
        check(v == 8, "R5 clamp", v, 8);
        reg_write(0, 64'h1_0000_0003 & 64'hFFFF_FFFF | 64'h8000_0000);
        reg_read(0, v);
        check(v == 8, "R5 clamp hi", v, 8);
        reg_write(0, 3);
        reg_read(0, v);
        check(v == 3, "R5 load", v, 3);
        send_chk(-64, 40, 3, "R5 use");
    endtask

    task automatic t_boundary();
        reg_write(0, 8);
        @(negedge clk);
        in_valid = 1'b1; in_i = 12'(256); in_q = 12'(-256);
        reg_wr_en = 1'b1; reg_addr = 4'd0; reg_wr_data = 32'd0;
        @(negedge clk);
        reg_wr_en = 1'b0;
        in_i = 12'(256); in_q = 12'(-256);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && $signed(out_i) == 1, "R6 old", $signed(out_i), 1);
        check($signed(out_q) == -1, "R6 old", $signed(out_q), -1);
        @(negedge clk);
        check(out_valid && $signed(out_i) == 7, "R6 new", $signed(out_i), 7);
        check($signed(out_q) == -8, "R6 new", $signed(out_q), -8);
        @(negedge clk);
        check(out_valid == 1'b0, "R4 idle", longint'(out_valid), 0);
    endtask

    task automatic t_reg_map();
        longint v;
        reg_write(1, 32'h1234);
        reg_read(1, v);
        check(v == 0, "R8 ro", v, 0);
        for (int a = 2; a < 16; a++) begin
            reg_read(a, v);
            check(v == 0, "R8 unmapped", v, 0);
        end
    endtask

    // Sample with an idle cycle after it, so gaps are exercised.
    task automatic feed(input int i, input int q);
        @(negedge clk);
        in_valid = 1'b1; in_i = 12'(i); in_q = 12'(q);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_power();
        longint v;
        do_reset();
        for (int k = 0; k < BLK - 1; k++) feed(3, 4);
        reg_read(1, v);
        check(v == 0, "R9 partial", v, 0);
        feed(3, 4);
        reg_read(1, v);
        check(v == 25, "R7 avg", v, 25);
        for (int k = 0; k < BLK / 2; k++) feed(100, 0);
        reg_write(1, 999);
        reg_read(1, v);
        check(v == 25, "R7 hold", v, 25);
        for (int k = 0; k < BLK / 2; k++) feed(0, -100);
        reg_read(1, v);
        check(v == 10000, "R7 avg2", v, 10000);
        for (int k = 0; k < BLK; k++) feed(-2048, -2048);
        reg_read(1, v);
        check(v == 8388608, "R7 max", v, 8388608);
    endtask

    initial begin
        t_reset();
        t_msb_window();
        t_low_window();
        t_mid_window();
        t_clamp();
        t_boundary();
        t_reg_map();
        t_power();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                check(1'b0, "watchdog", 0, 1);
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule